// File: doc/BRIEF.md
# Cluster Register File with Shadow Condition Flags

This block is the register storage of one processing cluster: sixteen 32-bit registers with three combinational read ports and a single write port. Two read ports (A and B) feed the local ALU. The third port (X) is reserved for the mirrored neighbour cluster and the auxiliary multi-cycle unit. Next to every register sits a small set of flops. These hold flags taken from the value last written: the zero condition, the sign bit, and the three lowest bits. Because of this, a branch can test a pointer tag or a sign without reading the full word.

A condition evaluator picks one flag of one register. It applies an optional inversion and drives a single branch-taken line. Spilling a register to the control stack borrows read port A. Unspilling from the stack borrows the write port. Neither adds a port. The two shared paths follow a valid/ready rule. While `unsp_valid` is high, `wr_ready` is low and the ALU write offered in that cycle is not performed, so the ALU side must hold it and retry. While `spill_valid` is high, `ra_ready` is low and port A shows the register being spilled, so the ALU must not consume port A in that cycle. The unspill and spill paths themselves are never back-pressured. Port B, port X, the condition pins and the memory-group attributes are plain combinational signals.

Top module: `crf_top`

## Requirements
- R1: After reset every register reads zero on all ports, and every register's zero flag is set.
- R2: When `wr_valid` and `wr_ready` are both high at a rising edge, `wr_data` is stored at `wr_idx` and is visible on every read port from the next cycle on.
- R3: Ports A, B and X return the contents of the register their index selects, without a clock cycle of delay. The three ports are independent and may select the same register.
- R4: A read of a register in the same cycle in which that register is written returns the value held before the write.
- R5: `cond_taken` equals the selected flag of register `cond_idx`, XOR `cond_inv`. The condition codes are 0 = bit 0, 1 = bit 1, 2 = bit 2, 3 = bit 31 and 4 = value equal to zero.
- R6: Condition codes 5, 6 and 7 select a flag that always reads as 0, so `cond_taken` equals `cond_inv`.
- R7: `unsp_valid` stores `unsp_data` at `unsp_idx` through the single write port. While `unsp_valid` is high, `wr_ready` is low and no ALU write takes place. When `unsp_valid` is low, `wr_ready` is high.
- R8: While `spill_valid` is high, port A shows the register selected by `spill_idx` instead of the one selected by `ra_idx`, and `ra_ready` is low. Otherwise `ra_ready` is high.
- R9: `ra_mem`, `rb_mem` and `rx_mem` are high exactly when the index the port actually uses is 8 or above, which marks the upper eight registers as the memory-access group.
- R10: Flags change at the same edge as the register they describe. In the cycle of a write, the condition evaluator still sees the flags of the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_idx | input | 4 | Port A register index (ALU) |
| ra_data | output | 32 | Port A read data (spill data while spilling) |
| ra_ready | output | 1 | Port A serves the ALU this cycle |
| ra_mem | output | 1 | Port A register is in the memory group |
| rb_idx | input | 4 | Port B register index (ALU) |
| rb_data | output | 32 | Port B read data |
| rb_mem | output | 1 | Port B register is in the memory group |
| rx_idx | input | 4 | Port X register index (neighbour / auxiliary) |
| rx_data | output | 32 | Port X read data |
| rx_mem | output | 1 | Port X register is in the memory group |
| wr_valid | input | 1 | ALU write request |
| wr_ready | output | 1 | ALU write accepted this cycle |
| wr_idx | input | 4 | ALU write index |
| wr_data | input | 32 | ALU write data |
| unsp_valid | input | 1 | Unspill write from control stack |
| unsp_idx | input | 4 | Unspill target index |
| unsp_data | input | 32 | Unspill data |
| spill_valid | input | 1 | Spill read request, takes port A |
| spill_idx | input | 4 | Register to spill |
| cond_idx | input | 4 | Register whose flag is tested |
| cond_sel | input | 3 | Condition code |
| cond_inv | input | 1 | Invert the condition |
| cond_taken | output | 1 | Branch decision |

## Verification
A register that latched a wrong value, or that failed to keep its value, shows up as a data mismatch on whichever read port next selects it. The bench rotates indices across all three ports every cycle, so such a fault appears within a few cycles of the faulty edge. A stale or wrongly derived shadow flag does not affect the data ports at all. It is only visible through `cond_taken`, so the bench cycles the condition index and all eight condition codes, with both polarities. A wrong port arbitration shows as a lost or misplaced write, or as port A showing the wrong register during a spill, in the very same or the next cycle.

// File: rtl/crf_pkg.sv
package crf_pkg;

  typedef struct packed {
    logic zero;
    logic msb;
    logic b2;
    logic b1;
    logic b0;
  } crf_flags_t;

  typedef enum logic [2:0] {
    COND_BIT0 = 3'd0,
    COND_BIT1 = 3'd1,
    COND_BIT2 = 3'd2,
    COND_SIGN = 3'd3,
    COND_ZERO = 3'd4
  } crf_cond_e;

  localparam crf_flags_t CRF_FLAGS_RESET = '{zero: 1'b1, msb: 1'b0, b2: 1'b0, b1: 1'b0, b0: 1'b0};

endpackage

// File: rtl/crf_flag_gen.sv
module crf_flag_gen
  import crf_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output crf_flags_t       flags
);
  always_comb begin
    flags.zero = (value == '0);
    flags.msb  = value[WIDTH-1];
    flags.b2   = value[2];
    flags.b1   = value[1];
    flags.b0   = value[0];
  end
endmodule

// File: rtl/crf_store.sv
module crf_store
  import crf_pkg::*;
#(
  parameter int REGS  = 16,
  parameter int WIDTH = 32,
  localparam int IDX_W = $clog2(REGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDX_W-1:0]            widx,
  input  logic [WIDTH-1:0]            wdata,
  output logic [REGS-1:0][WIDTH-1:0]  mem_q,
  output crf_flags_t [REGS-1:0]       flg_q
);
  crf_flags_t wflags;

  crf_flag_gen #(.WIDTH(WIDTH)) u_fgen (
    .value (wdata),
    .flags (wflags)
  );

  for (genvar g = 0; g < REGS; g++) begin : g_entry
    logic hit;
    assign hit = we && (widx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
        flg_q[g] <= CRF_FLAGS_RESET;
      end else if (hit) begin
        mem_q[g] <= wdata;
        flg_q[g] <= wflags;
      end
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(widx)] == $past(wdata)); // R2

  AST_FLAG_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> flg_q[$past(widx)].zero == ($past(wdata) == '0)); // R10

  AST_FLAG_SIGN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> flg_q[$past(widx)].msb == $past(wdata[WIDTH-1])); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> mem_q == $past(mem_q)); // R2
endmodule

// File: rtl/crf_cond_eval.sv
module crf_cond_eval
  import crf_pkg::*;
#(
  parameter int REGS = 16,
  localparam int IDX_W = $clog2(REGS)
) (
  input  crf_flags_t [REGS-1:0] flg,
  input  logic [IDX_W-1:0]      idx,
  input  logic [2:0]            sel,
  input  logic                  inv,
  output logic                  taken
);
  crf_flags_t picked;
  logic       raw;

  always_comb begin
    picked = flg[idx];
    case (sel)
      COND_BIT0: raw = picked.b0;
      COND_BIT1: raw = picked.b1;
      COND_BIT2: raw = picked.b2;
      COND_SIGN: raw = picked.msb;
      COND_ZERO: raw = picked.zero;
      default:   raw = 1'b0;
    endcase
    taken = raw ^ inv;
  end

  always_comb begin
    if (sel > 3'd4) begin
      AST_RESERVED_CODE: assert (taken == inv); // R6
    end
  end
endmodule

// File: rtl/crf_top.sv
module crf_top
  import crf_pkg::*;
#(
  parameter int REGS     = 16,
  parameter int WIDTH    = 32,
  parameter int MEM_REGS = 8,
  localparam int IDX_W    = $clog2(REGS),
  localparam int MEM_BASE = REGS - MEM_REGS,
  localparam int PORTS    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [WIDTH-1:0] ra_data,
  output logic             ra_ready,
  output logic             ra_mem,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [WIDTH-1:0] rb_data,
  output logic             rb_mem,
  input  logic [IDX_W-1:0] rx_idx,
  output logic [WIDTH-1:0] rx_data,
  output logic             rx_mem,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             unsp_valid,
  input  logic [IDX_W-1:0] unsp_idx,
  input  logic [WIDTH-1:0] unsp_data,
  input  logic             spill_valid,
  input  logic [IDX_W-1:0] spill_idx,
  input  logic [IDX_W-1:0] cond_idx,
  input  logic [2:0]       cond_sel,
  input  logic             cond_inv,
  output logic             cond_taken
);
  logic                       st_we;
  logic [IDX_W-1:0]           st_widx;
  logic [WIDTH-1:0]           st_wdata;
  logic [REGS-1:0][WIDTH-1:0] st_mem;
  crf_flags_t [REGS-1:0]      st_flg;

  // Write port arbitration: unspill owns the port when present.
  always_comb begin
    wr_ready = !unsp_valid;
    st_we    = unsp_valid || wr_valid;
    st_widx  = unsp_valid ? unsp_idx  : wr_idx;
    st_wdata = unsp_valid ? unsp_data : wr_data;
  end

  crf_store #(.REGS(REGS), .WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .widx  (st_widx),
    .wdata (st_wdata),
    .mem_q (st_mem),
    .flg_q (st_flg)
  );

  // Read ports: port 0 is shared with spill.
  logic [PORTS-1:0][IDX_W-1:0] p_idx;
  logic [PORTS-1:0][WIDTH-1:0] p_data;
  logic [PORTS-1:0]            p_mem;

  assign p_idx[0] = spill_valid ? spill_idx : ra_idx;
  assign p_idx[1] = rb_idx;
  assign p_idx[2] = rx_idx;

  for (genvar p = 0; p < PORTS; p++) begin : g_rport
    assign p_data[p] = st_mem[p_idx[p]];
    assign p_mem[p]  = (int'(p_idx[p]) >= MEM_BASE);
  end

  assign ra_data  = p_data[0];
  assign rb_data  = p_data[1];
  assign rx_data  = p_data[2];
  assign ra_mem   = p_mem[0];
  assign rb_mem   = p_mem[1];
  assign rx_mem   = p_mem[2];
  assign ra_ready = !spill_valid;

  crf_cond_eval #(.REGS(REGS)) u_cond (
    .flg   (st_flg),
    .idx   (cond_idx),
    .sel   (cond_sel),
    .inv   (cond_inv),
    .taken (cond_taken)
  );

  AST_UNSPILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    unsp_valid |=> st_mem[$past(unsp_idx)] == $past(unsp_data)); // R7

  AST_ALU_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> st_mem[$past(wr_idx)] == $past(wr_data)); // R2

  AST_SPILL_SHOWS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid |-> ra_data == rx_data || rx_idx != spill_idx); // R8
endmodule

// File: tb/crf_top_bench.sv
module crf_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ra_idx, rb_idx, rx_idx, wr_idx, unsp_idx, spill_idx, cond_idx;
  logic [31:0] ra_data, rb_data, rx_data, wr_data, unsp_data;
  logic        ra_ready, ra_mem, rb_mem, rx_mem, wr_valid, wr_ready;
  logic        unsp_valid, spill_valid, cond_inv, cond_taken;
  logic [2:0]  cond_sel;

  int          n_run  = 0;
  int          n_fail = 0;
  logic [31:0] ref_q [16];

  always #5 clk = ~clk;

  crf_top u_crf_top (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ra_idx), .ra_data(ra_data), .ra_ready(ra_ready), .ra_mem(ra_mem),
    .rb_idx(rb_idx), .rb_data(rb_data), .rb_mem(rb_mem),
    .rx_idx(rx_idx), .rx_data(rx_data), .rx_mem(rx_mem),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
    .unsp_valid(unsp_valid), .unsp_idx(unsp_idx), .unsp_data(unsp_data),
    .spill_valid(spill_valid), .spill_idx(spill_idx),
    .cond_idx(cond_idx), .cond_sel(cond_sel), .cond_inv(cond_inv),
    .cond_taken(cond_taken)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic ref_flag(input logic [31:0] v, input logic [2:0] s);
    case (s)
      3'd0: return v[0];
      3'd1: return v[1];
      3'd2: return v[2];
      3'd3: return v[31];
      3'd4: return (v == 32'd0);
      default: return 1'b0;
    endcase
  endfunction

  // Compare all outputs with the model state that precedes the next edge.
  task automatic compare_all(input string tag);
    logic [3:0] a_eff;
    a_eff = spill_valid ? spill_idx : ra_idx;
    chk(spill_valid ? "R8" : "R3", {tag, " ra_data"}, ra_data, ref_q[a_eff]);
    chk("R8", {tag, " ra_ready"}, 32'(ra_ready), 32'(!spill_valid));
    chk("R3", {tag, " rb_data"}, rb_data, ref_q[rb_idx]);
    chk("R3", {tag, " rx_data"}, rx_data, ref_q[rx_idx]);
    chk("R9", {tag, " mem attrs"}, {29'd0, ra_mem, rb_mem, rx_mem},
        {29'd0, a_eff >= 4'd8, rb_idx >= 4'd8, rx_idx >= 4'd8});
    chk("R7", {tag, " wr_ready"}, 32'(wr_ready), 32'(!unsp_valid));
    chk(cond_sel > 3'd4 ? "R6" : "R5", {tag, " cond_taken"}, 32'(cond_taken),
        32'(ref_flag(ref_q[cond_idx], cond_sel) ^ cond_inv));
  endtask

  task automatic step(input string tag);
    #1 compare_all(tag);
    @(posedge clk);
    if (unsp_valid)    ref_q[unsp_idx] = unsp_data;
    else if (wr_valid) ref_q[wr_idx]   = wr_data;
    @(negedge clk);
  endtask

  task automatic idle();
    wr_valid = 0; unsp_valid = 0; spill_valid = 0; cond_inv = 0;
    ra_idx = 0; rb_idx = 0; rx_idx = 0; wr_idx = 0; unsp_idx = 0; spill_idx = 0;
    cond_idx = 0; cond_sel = 3'd4; wr_data = 0; unsp_data = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_q[i] = 32'd0;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state on every register and its zero flag
    for (int i = 0; i < 16; i++) begin
      ra_idx = 4'(i); rb_idx = 4'(15 - i); rx_idx = 4'(i); cond_idx = 4'(i); cond_sel = 3'd4;
      #1 chk("R1", "reset read", ra_data, 32'd0);
      chk("R1", "reset zero flag", 32'(cond_taken), 32'd1);
      @(negedge clk);
    end

    // R2 / R4 / R10: write reg 5, same-cycle read and condition see old state
    idle();
    wr_valid = 1; wr_idx = 4'd5; wr_data = 32'h8000_0007;
    ra_idx = 4'd5; cond_idx = 4'd5; cond_sel = 3'd4;
    #1 chk("R4", "same-cycle read old", ra_data, 32'd0);
    chk("R10", "same-cycle flag old", 32'(cond_taken), 32'd1);
    @(posedge clk); ref_q[5] = 32'h8000_0007; @(negedge clk);
    wr_valid = 0;
    #1 chk("R2", "written value", ra_data, 32'h8000_0007);
    chk("R10", "zero flag after write", 32'(cond_taken), 32'd0);
    cond_sel = 3'd3; #1 chk("R5", "sign flag", 32'(cond_taken), 32'd1);
    cond_sel = 3'd2; cond_inv = 1; #1 chk("R5", "bit2 inverted", 32'(cond_taken), 32'd0);
    cond_sel = 3'd6; cond_inv = 0; #1 chk("R6", "reserved code", 32'(cond_taken), 32'd0);
    cond_inv = 1; #1 chk("R6", "reserved inverted", 32'(cond_taken), 32'd1);
    @(negedge clk);

    // R7: unspill beats ALU write in the same cycle
    idle();
    wr_valid = 1; wr_idx = 4'd9; wr_data = 32'h1111_1111;
    unsp_valid = 1; unsp_idx = 4'd9; unsp_data = 32'h2222_2222;
    #1 chk("R7", "wr_ready low", 32'(wr_ready), 32'd0);
    @(posedge clk); ref_q[9] = 32'h2222_2222; @(negedge clk);
    idle(); rb_idx = 4'd9;
    #1 chk("R7", "unspill value", rb_data, 32'h2222_2222);
    chk("R9", "reg 9 in memory group", 32'(rb_mem), 32'd1);

    // R8: spill takes port A
    spill_valid = 1; spill_idx = 4'd5; ra_idx = 4'd9;
    #1 chk("R8", "spill data", ra_data, 32'h8000_0007);
    chk("R8", "ra_ready low", 32'(ra_ready), 32'd0);
    chk("R9", "spill index attr", 32'(ra_mem), 32'd0);
    @(negedge clk);

    // Randomised traffic against the model, every cycle
    for (int c = 0; c < 3000; c++) begin
      wr_valid    = ($urandom % 3) != 0;
      wr_idx      = 4'($urandom);
      case ($urandom % 4)
        0: wr_data = 32'd0;
        1: wr_data = 32'($urandom % 8);
        default: wr_data = $urandom;
      endcase
      unsp_valid  = ($urandom % 5) == 0;
      unsp_idx    = 4'($urandom);
      unsp_data   = $urandom;
      spill_valid = ($urandom % 6) == 0;
      spill_idx   = 4'($urandom);
      ra_idx      = 4'($urandom);
      rb_idx      = ($urandom % 3 == 0) ? wr_idx : 4'($urandom);
      rx_idx      = 4'($urandom);
      cond_idx    = ($urandom % 3 == 0) ? wr_idx : 4'($urandom);
      cond_sel    = 3'($urandom);
      cond_inv    = 1'($urandom);
      step("random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule